// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Controller

This block holds the pending interprocessor-interrupt (IPI) state and the pending interval-timer state for up to four processors. Software reaches it through a small register port. A processor can post IPIs to other processors, or to itself, and can clear them. It can also acknowledge timer interrupts. It does this either through packed command fields in one control word or through three dedicated registers. A one-cycle `timer_tick` pulse from an external period generator marks a timer interrupt pending on every present processor.

Each present processor has one IPI line, which is its level-3 request, and one timer line, which is its level-2 request. Both lines come straight from that processor's pending state. Some requests are redundant: posting an IPI that is already pending, or clearing one that is not pending. These requests do not change the state, and they raise a one-cycle warning. A write that carries no command at all raises a one-cycle error.

Each processor slot holds two two-state machines. The IPI machine has the states `IPI_IDLE` and `IPI_PEND`. A post moves it from `IPI_IDLE` to `IPI_PEND`. A clear with no post in the same cycle moves it from `IPI_PEND` back to `IPI_IDLE`. The timer machine has the states `TMR_IDLE` and `TMR_PEND`. A tick moves it from `TMR_IDLE` to `TMR_PEND`. A clear with no tick in the same cycle moves it from `TMR_PEND` back to `TMR_IDLE`. Every other input combination leaves the state where it is.

Top module: `ipi_timer_intc`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ipi_irq`, `tmr_irq`, `warn`, `err` and `csr_rdata` are all zero.
- R2: A write to register select 0 (control) with a bit set in `csr_wdata[15:12]` makes IPI pending for CPU n, where bit 12+n selects CPU n. The pending bit is visible on `ipi_irq[n]` after the write's clock edge.
- R3: In a control write, `csr_wdata[11:8]` clears pending IPIs and `csr_wdata[7:4]` clears pending timer interrupts, with bit 8+n or 4+n selecting CPU n. All fields present in one write take effect at the same edge.
- R4: A control write whose bits 15:4 are all zero raises `err` for exactly the cycle after the write edge, and no pending bit changes. If bit 28 is set in such a write, it is accepted silently, with no `err` and no change.
- R5: A post for a CPU whose IPI is already pending leaves the state unchanged and raises `warn` for the cycle after the write edge.
- R6: A clear for a CPU with no pending IPI leaves the state unchanged and raises `warn` for the cycle after the write edge.
- R7: A `timer_tick` pulse makes the timer interrupt pending for every present CPU after that clock edge.
- R8: Bits 3:0 of a write select CPUs 0 to 3 in the dedicated registers. A write to select 1 clears those CPUs' IPIs. A write to select 2 clears their timer interrupts. A write to select 3 posts IPIs to them. A read of select 1 returns the pending IPI bits in bits 3:0, and a read of select 2 returns the pending timer bits in bits 3:0.
- R9: A write to select 1, 2 or 3 with `csr_wdata[3:0]` equal to zero raises `err` for the cycle after the write edge and changes nothing.
- R10: A read of select 0 returns the pending IPIs in bits 11:8, the pending timers in bits 7:4 and `csr_cpu` in bits 1:0. `csr_rdata` holds the value registered at the read edge.
- R11: CPUs numbered `NCPU` and above are never posted, cleared or ticked. Their request bits produce neither a state change nor a warning.
- R12: When a clear and a post reach the same CPU in one cycle, the clear is applied first and the CPU ends up pending. A timer clear in the same cycle as a tick likewise leaves the timer pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_sel | input | 2 | Register select: 0 control, 1 IPI status, 2 timer status, 3 IPI request |
| csr_wdata | input | 32 | Write data |
| csr_cpu | input | 2 | Number of the requesting CPU |
| csr_rdata | output | 32 | Registered read data |
| timer_tick | input | 1 | One-cycle interval-timer pulse |
| ipi_irq | output | 4 | Level-3 IPI request per CPU |
| tmr_irq | output | 4 | Level-2 timer request per CPU |
| warn | output | 1 | Redundant post or clear, one cycle |
| err | output | 1 | Write with no command, one cycle |

## Verification
Every result is due one register stage after its stimulus. This covers pending lines, `warn`, `err` and read data, which all change at the same clock edge that samples the write, read or tick. The bench drives each stimulus on a falling edge and then waits one rising edge. It compares all outputs on the next falling edge, half a period after they settle. The bench instantiates the block with three CPUs, so absent-CPU bits can be observed at the ports.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
    localparam int MAX_CPUS = 4;
    localparam int CPU_IDW  = 2;
    localparam int DATA_W   = 32;

    // control-word field positions
    localparam int POST_LSB   = 12;
    localparam int IPICLR_LSB = 8;
    localparam int TMRCLR_LSB = 4;
    localparam int QUIET_BIT  = 28;

    typedef enum logic [1:0] {
        REG_CTRL     = 2'd0,
        REG_IPI_STAT = 2'd1,
        REG_TMR_STAT = 2'd2,
        REG_IPI_REQ  = 2'd3
    } reg_sel_e;

    typedef enum logic { IPI_IDLE = 1'b0, IPI_PEND = 1'b1 } ipi_state_e;
    typedef enum logic { TMR_IDLE = 1'b0, TMR_PEND = 1'b1 } tmr_state_e;

    typedef struct packed {
        logic [MAX_CPUS-1:0] post;
        logic [MAX_CPUS-1:0] clr_ipi;
        logic [MAX_CPUS-1:0] clr_tmr;
        logic                bad;
    } cmd_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd
);
    localparam logic [MAX_CPUS-1:0] PRESENT = MAX_CPUS'((1 << NCPU) - 1);

    logic [MAX_CPUS-1:0] f_post, f_cipi, f_ctmr, f_low;
    logic                unused_hi;

    assign f_post    = wdata[POST_LSB   +: MAX_CPUS];
    assign f_cipi    = wdata[IPICLR_LSB +: MAX_CPUS];
    assign f_ctmr    = wdata[TMRCLR_LSB +: MAX_CPUS];
    assign f_low     = wdata[MAX_CPUS-1:0];
    assign unused_hi = ^{wdata[DATA_W-1:QUIET_BIT+1], wdata[QUIET_BIT-1:POST_LSB+MAX_CPUS]};

    always_comb begin
        cmd = '0;
        if (wr) begin
            unique case (reg_sel_e'(sel))
                REG_CTRL: begin
                    cmd.post    = f_post & PRESENT;
                    cmd.clr_ipi = f_cipi & PRESENT;
                    cmd.clr_tmr = f_ctmr & PRESENT;
                    cmd.bad     = (f_post == '0) && (f_cipi == '0) &&
                                  (f_ctmr == '0) && !wdata[QUIET_BIT];
                end
                REG_IPI_STAT: begin
                    cmd.clr_ipi = f_low & PRESENT;
                    cmd.bad     = (f_low == '0);
                end
                REG_TMR_STAT: begin
                    cmd.clr_tmr = f_low & PRESENT;
                    cmd.bad     = (f_low == '0);
                end
                REG_IPI_REQ: begin
                    cmd.post    = f_low & PRESENT;
                    cmd.bad     = (f_low == '0);
                end
                default: cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
    import ipi_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic clr_ipi,
    input  logic clr_tmr,
    input  logic tick,
    output logic ipi_pend,
    output logic tmr_pend,
    output logic warn_now
);
    ipi_state_e ipi_q, ipi_d;
    tmr_state_e tmr_q, tmr_d;

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipi_q <= IPI_IDLE;
            tmr_q <= TMR_IDLE;
        end else begin
            ipi_q <= ipi_d;
            tmr_q <= tmr_d;
        end
    end

    // transitions: a clear is applied before a post or tick
    always_comb begin
        ipi_d = ipi_q;
        unique case (ipi_q)
            IPI_IDLE: if (post)             ipi_d = IPI_PEND;
            IPI_PEND: if (clr_ipi && !post) ipi_d = IPI_IDLE;
            default:                        ipi_d = IPI_IDLE;
        endcase
        tmr_d = tmr_q;
        unique case (tmr_q)
            TMR_IDLE: if (tick)             tmr_d = TMR_PEND;
            TMR_PEND: if (clr_tmr && !tick) tmr_d = TMR_IDLE;
            default:                        tmr_d = TMR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ipi_pend = (ipi_q == IPI_PEND);
        tmr_pend = (tmr_q == TMR_PEND);
        unique case (ipi_q)
            IPI_IDLE: warn_now = clr_ipi;
            IPI_PEND: warn_now = post && !clr_ipi;
            default:  warn_now = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
    import ipi_tmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic [1:0]          sel,
    input  logic [CPU_IDW-1:0]  cpu,
    input  logic [MAX_CPUS-1:0] ipi,
    input  logic [MAX_CPUS-1:0] tmr,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        unique case (reg_sel_e'(sel))
            REG_CTRL: begin
                rd_d[IPICLR_LSB +: MAX_CPUS] = ipi;
                rd_d[TMRCLR_LSB +: MAX_CPUS] = tmr;
                rd_d[CPU_IDW-1:0]            = cpu;
            end
            REG_IPI_STAT: rd_d[MAX_CPUS-1:0] = ipi;
            REG_TMR_STAT: rd_d[MAX_CPUS-1:0] = tmr;
            REG_IPI_REQ:  rd_d = '0;
            default:      rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_d;
    end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic                csr_rd,
    input  logic [1:0]          csr_sel,
    input  logic [DATA_W-1:0]   csr_wdata,
    input  logic [CPU_IDW-1:0]  csr_cpu,
    output logic [DATA_W-1:0]   csr_rdata,
    input  logic                timer_tick,
    output logic [MAX_CPUS-1:0] ipi_irq,
    output logic [MAX_CPUS-1:0] tmr_irq,
    output logic                warn,
    output logic                err
);
    cmd_t                cmd;
    logic [MAX_CPUS-1:0] warn_vec;

    ipi_cmd_decode #(.NCPU(NCPU)) u_dec (
        .wr    (csr_wr),
        .sel   (csr_sel),
        .wdata (csr_wdata),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < MAX_CPUS; i++) begin : g_cpu
        if (i < NCPU) begin : g_on
            ipi_cpu_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .post     (cmd.post[i]),
                .clr_ipi  (cmd.clr_ipi[i]),
                .clr_tmr  (cmd.clr_tmr[i]),
                .tick     (timer_tick),
                .ipi_pend (ipi_irq[i]),
                .tmr_pend (tmr_irq[i]),
                .warn_now (warn_vec[i])
            );
        end else begin : g_off
            assign ipi_irq[i]  = 1'b0;
            assign tmr_irq[i]  = 1'b0;
            assign warn_vec[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn <= 1'b0;
            err  <= 1'b0;
        end else begin
            warn <= |warn_vec;
            err  <= cmd.bad;
        end
    end

    ipi_readback u_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (csr_rd),
        .sel   (csr_sel),
        .cpu   (csr_cpu),
        .ipi   (ipi_irq),
        .tmr   (tmr_irq),
        .rdata (csr_rdata)
    );
endmodule

// File: rtl/ipi_timer_intc_chk.sv
module ipi_timer_intc_chk #(
    parameter int NCPU = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       csr_wr,
    input logic [1:0] csr_sel,
    input logic [3:0] req_bits,
    input logic       timer_tick,
    input logic [3:0] ipi_irq,
    input logic [3:0] tmr_irq,
    input logic       warn,
    input logic       err
);
    localparam logic [3:0] PRESENT = 4'((1 << NCPU) - 1);

    assert_tick_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tick |=> ((tmr_irq & PRESENT) == PRESENT));

    assert_req_posts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == 2'd3) |=>
            ((ipi_irq & $past(req_bits) & PRESENT) == ($past(req_bits) & PRESENT)));

    assert_stat_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == 2'd1) |=> ((ipi_irq & $past(req_bits)) == 4'd0));

    assert_err_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(ipi_irq));

    assert_warn_err_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(warn && err));

    assert_idle_clear_warns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel == 2'd1 && ((req_bits & PRESENT & ~ipi_irq) != 4'd0)) |=> warn);
endmodule

bind ipi_timer_intc ipi_timer_intc_chk #(.NCPU(NCPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_wr     (csr_wr),
    .csr_sel    (csr_sel),
    .req_bits   (csr_wdata[3:0]),
    .timer_tick (timer_tick),
    .ipi_irq    (ipi_irq),
    .tmr_irq    (tmr_irq),
    .warn       (warn),
    .err        (err)
);

// File: tb/ipi_timer_intc_test.sv
module ipi_timer_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0, csr_rd = 1'b0, timer_tick = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  csr_cpu = 2'd2;
    logic [31:0] csr_rdata;
    logic [3:0]  ipi_irq, tmr_irq;
    logic        warn, err;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    ipi_timer_intc #(.NCPU(3)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_cpu(csr_cpu),
        .csr_rdata(csr_rdata), .timer_tick(timer_tick),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn(warn), .err(err)
    );

    // op: 0 write+tick, 1 write, 2 read, 3 tick
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sel;
        logic [31:0] data;
        logic [3:0]  ipi;
        logic [3:0]  tmr;
        logic        wrn;
        logic        er;
        logic [31:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 32'h0000_3000, 4'b0011, 4'b0000, 1'b0, 1'b0, 32'h0, 8'd2},  // R2 post 0,1
        '{2'd2, 2'd1, 32'h0,         4'b0011, 4'b0000, 1'b0, 1'b0, 32'h3, 8'd8},  // R8 read ipi
        '{2'd1, 2'd0, 32'h0000_1000, 4'b0011, 4'b0000, 1'b1, 1'b0, 32'h0, 8'd5},  // R5 repost
        '{2'd1, 2'd0, 32'h0000_0400, 4'b0011, 4'b0000, 1'b1, 1'b0, 32'h0, 8'd6},  // R6 idle clear
        '{2'd3, 2'd0, 32'h0,         4'b0011, 4'b0111, 1'b0, 1'b0, 32'h0, 8'd7},  // R7 tick
        '{2'd1, 2'd0, 32'h0000_0120, 4'b0010, 4'b0101, 1'b0, 1'b0, 32'h0, 8'd3},  // R3 both clears
        '{2'd2, 2'd0, 32'h0,         4'b0010, 4'b0101, 1'b0, 1'b0, 32'h252, 8'd10}, // R10 ctrl read
        '{2'd1, 2'd0, 32'h0,         4'b0010, 4'b0101, 1'b0, 1'b1, 32'h0, 8'd4},  // R4 empty
        '{2'd1, 2'd0, 32'h1000_0000, 4'b0010, 4'b0101, 1'b0, 1'b0, 32'h0, 8'd4},  // R4 quiet
        '{2'd1, 2'd3, 32'h8,         4'b0010, 4'b0101, 1'b0, 1'b0, 32'h0, 8'd11}, // R11 absent
        '{2'd1, 2'd3, 32'h4,         4'b0110, 4'b0101, 1'b0, 1'b0, 32'h0, 8'd8},  // R8 request
        '{2'd1, 2'd1, 32'h0,         4'b0110, 4'b0101, 1'b0, 1'b1, 32'h0, 8'd9},  // R9 zero
        '{2'd1, 2'd1, 32'h6,         4'b0000, 4'b0101, 1'b0, 1'b0, 32'h0, 8'd8},  // R8 ipi clear
        '{2'd1, 2'd2, 32'h4,         4'b0000, 4'b0001, 1'b0, 1'b0, 32'h0, 8'd8},  // R8 tmr clear
        '{2'd2, 2'd2, 32'h0,         4'b0000, 4'b0001, 1'b0, 1'b0, 32'h1, 8'd8},  // R8 read tmr
        '{2'd1, 2'd0, 32'h0000_1100, 4'b0001, 4'b0001, 1'b1, 1'b0, 32'h0, 8'd12}, // R12 clr+post idle
        '{2'd1, 2'd0, 32'h0000_1100, 4'b0001, 4'b0001, 1'b0, 1'b0, 32'h0, 8'd12}, // R12 clr+post pend
        '{2'd1, 2'd2, 32'h0,         4'b0001, 4'b0001, 1'b0, 1'b1, 32'h0, 8'd9},  // R9 zero
        '{2'd0, 2'd2, 32'h7,         4'b0001, 4'b0111, 1'b0, 1'b0, 32'h0, 8'd12}  // R12 tick+clear
    };

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("ipi in reset", 1, {28'd0, ipi_irq}, 32'd0);
        check("tmr in reset", 1, {28'd0, tmr_irq}, 32'd0);
        check("flags in reset", 1, {30'd0, warn, err}, 32'd0);
        check("rdata in reset", 1, csr_rdata, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            csr_sel    = VECS[k].sel;
            csr_wdata  = VECS[k].data;
            csr_wr     = (VECS[k].op == 2'd0) || (VECS[k].op == 2'd1);
            csr_rd     = (VECS[k].op == 2'd2);
            timer_tick = (VECS[k].op == 2'd0) || (VECS[k].op == 2'd3);
            @(negedge clk);
            csr_wr = 0; csr_rd = 0; timer_tick = 0;
            check("ipi_irq", int'(VECS[k].req), {28'd0, ipi_irq}, {28'd0, VECS[k].ipi});
            check("tmr_irq", int'(VECS[k].req), {28'd0, tmr_irq}, {28'd0, VECS[k].tmr});
            check("warn",    int'(VECS[k].req), {31'd0, warn},    {31'd0, VECS[k].wrn});
            check("err",     int'(VECS[k].req), {31'd0, err},     {31'd0, VECS[k].er});
            if (VECS[k].op == 2'd2)
                check("rdata", int'(VECS[k].req), csr_rdata, VECS[k].rd);
        end

        // R11: ticks never reach absent CPU 3; warn pulse lasts one cycle (R5)
        @(negedge clk);
        check("warn drop", 5, {31'd0, warn}, 32'd0);
        check("absent cpu3", 11, {30'd0, ipi_irq[3], tmr_irq[3]}, 32'd0);

        // R1: reset mid-run clears pending state and read data
        rst_n = 1'b0;
        @(negedge clk);
        check("ipi after reset", 1, {28'd0, ipi_irq}, 32'd0);
        check("tmr after reset", 1, {28'd0, tmr_irq}, 32'd0);
        check("rdata after reset", 1, csr_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("ipi first cycle", 1, {28'd0, ipi_irq}, 32'd0);
        finish_run();
    end

    initial begin
        #(4 * 5000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule